// File: doc/BRIEF.md
# Sector-Buffered Flash Write Emulator

This block is a synchronous, device-side model of a byte-wide nonvolatile memory that is rewritten one 64-byte sector at a time. A parallel bus (15-bit address, byte in, byte out, active-low chip enable, output enable and write enable) is sampled on the system clock. Reads behave like a plain ROM. Writes reach the array only after a three-write unlock sequence opens a load window. The bytes of one sector are collected in a buffer until no further write begins for a set number of cycles. The sector is then erased and programmed as a whole, and bytes that were not loaded read back as FFh.

While the block is busy, any read returns a status byte instead of data. Bit 7 is the inverse of bit 7 of the last byte written, and bit 6 changes on each new read. A second command sequence switches reads to two fixed identification codes, and a third switches them back. Timing is counted in clock cycles. The load-window and busy lengths default to 150 µs and 20 ms at `CLK_HZ` and can be overridden with short values for simulation. The array holds `NSECT` sectors. The full 32K-byte part uses `NSECT = 512`. With fewer sectors, the low bits of the sector field pick the sector.

Top module: `sector_flash_emu`

## Requirements
- R1: After reset every byte reads FFh, identification mode is off and `data_oe_o` is low.
- R2: A read is `ce_ni`=0, `oe_ni`=0, `we_ni`=1 on a clock edge. At the following edge `data_oe_o` goes high and `data_o` carries the byte. With `ce_ni` or `oe_ni` high, `data_oe_o` is low.
- R3: Data AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h opens a load window. A write that does not match the next step of the sequence returns the decoder to its first step. That write stores nothing and starts a busy period.
- R4: In the load window, `addr_i[5:0]` picks the byte and the bytes may come in any order. The sector is taken from `addr_i[14:6]` of the first byte, using its low log2(`NSECT`) bits. A repeated offset keeps the last value written.
- R5: The window closes once `BLC_CYC` cycles pass after the end of a write with no new write starting. A new write that starts earlier extends the window. A window that closes with no byte loaded ends without a busy period.
- R6: On close, the selected sector is erased and programmed in one step. Loaded bytes hold their new values, the other bytes of that sector read FFh, and all other sectors are left unchanged.
- R7: The busy period lasts `PROG_CYC` cycles and ignores all writes. After it ends, protection is back: a write without the unlock sequence stores nothing.
- R8: A read during busy returns bit 7 inverted from the last written byte, with bits 5..0 equal to that byte's bits 5..0.
- R9: During busy, bit 6 reads 1 on the first read of the period and inverts on each later read, that is, each time the read condition starts again.
- R10: AAh/5555h, 55h/2AAAh, 90h/5555h enters identification mode. In that mode reads return 1Fh when `addr_i[0]`=0 and BCh when `addr_i[0]`=1. AAh/5555h, 55h/2AAAh, F0h/5555h leaves the mode, and the array is not changed by either sequence.
- R11: A write is recognised only while `ce_ni`=0, `we_ni`=0 and `oe_ni`=1. A write strobe with `oe_ni` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | Byte address: sector in bits 14..6, offset in bits 5..0 |
| data_i | input | 8 | Write data |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| data_o | output | 8 | Read data or busy status, registered |
| data_oe_o | output | 1 | High while the block drives `data_o` |

## Verification
If the unlock decoder is left in the wrong step, the next command write either starts a busy period that should not happen or fails to open a window. Either fault shows as a status byte, or as an unchanged byte, on the very next read. A bad buffer mask or sector latch stays hidden until the window closes and the busy period ends. After that, a read of any byte in the sector exposes it, because each byte must hold either the loaded value or FFh. A wrong toggle or polling register shows within one read of the start of the busy period.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int BUS_AW = 15;
  localparam int DW     = 8;
  localparam int OFS_W  = 6;
  localparam int SECT_BYTES = 1 << OFS_W;

  localparam logic [BUS_AW-1:0] UNLK_ADDR_A = 15'h5555;
  localparam logic [BUS_AW-1:0] UNLK_ADDR_B = 15'h2AAA;
  localparam logic [DW-1:0] KEY_1     = 8'hAA;
  localparam logic [DW-1:0] KEY_2     = 8'h55;
  localparam logic [DW-1:0] OP_PROG   = 8'hA0;
  localparam logic [DW-1:0] OP_ID_ON  = 8'h90;
  localparam logic [DW-1:0] OP_ID_OFF = 8'hF0;
  localparam logic [DW-1:0] ID_MFR    = 8'h1F;
  localparam logic [DW-1:0] ID_DEV    = 8'hBC;
  localparam logic [DW-1:0] ERASED    = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_BUSY} ctl_state_e;
  typedef enum logic [1:0] {STEP_0, STEP_1, STEP_2} cmd_step_e;
  typedef enum logic [2:0] {CMD_NONE, CMD_PROG, CMD_ID_ON, CMD_ID_OFF, CMD_BAD} cmd_e;
endpackage

// File: rtl/sfe_bus_if.sv
module sfe_bus_if
  import sfe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  output logic              wr_act_o,
  output logic              wr_start_o,
  output logic              wr_evt_o,
  output logic [BUS_AW-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              rd_act_o,
  output logic              rd_start_o
);
  logic strobe, rd, strobe_q, rd_q;
  logic [BUS_AW-1:0] addr_q;
  logic [DW-1:0]     data_q;

  assign strobe = !ce_ni && !we_ni && oe_ni;
  assign rd     = !ce_ni && !oe_ni && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      rd_q     <= rd;
      // address at strobe start, data held until strobe end
      if (strobe && !strobe_q) addr_q <= addr_i;
      if (strobe)              data_q <= data_i;
    end
  end

  assign wr_act_o   = strobe;
  assign wr_start_o = strobe && !strobe_q;
  assign wr_evt_o   = !strobe && strobe_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign rd_act_o   = rd;
  assign rd_start_o = rd && !rd_q;
endmodule

// File: rtl/sfe_cmd_fsm.sv
module sfe_cmd_fsm
  import sfe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_evt_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output cmd_e              cmd_o,
  output cmd_step_e         step_o
);
  cmd_step_e step_q, step_d;
  cmd_e      cmd;

  always_comb begin
    step_d = step_q;
    cmd    = CMD_NONE;
    if (en_i && wr_evt_i) begin
      step_d = STEP_0;
      cmd    = CMD_BAD;
      unique case (step_q)
        STEP_0: if (addr_i == UNLK_ADDR_A && data_i == KEY_1) begin
          step_d = STEP_1;
          cmd    = CMD_NONE;
        end
        STEP_1: if (addr_i == UNLK_ADDR_B && data_i == KEY_2) begin
          step_d = STEP_2;
          cmd    = CMD_NONE;
        end
        STEP_2: if (addr_i == UNLK_ADDR_A) begin
          if (data_i == OP_PROG)        cmd = CMD_PROG;
          else if (data_i == OP_ID_ON)  cmd = CMD_ID_ON;
          else if (data_i == OP_ID_OFF) cmd = CMD_ID_OFF;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= STEP_0;
    else if (!en_i)  step_q <= STEP_0;
    else             step_q <= step_d;
  end

  assign cmd_o  = cmd;
  assign step_o = step_q;
endmodule

// File: rtl/sfe_sector_buf.sv
module sfe_sector_buf
  import sfe_pkg::*;
#(
  parameter int SW = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_i,
  input  logic [OFS_W-1:0]          ofs_i,
  input  logic [SW-1:0]             sec_i,
  input  logic [DW-1:0]             data_i,
  output logic [SECT_BYTES-1:0][DW-1:0] bytes_o,
  output logic [SECT_BYTES-1:0]     mask_o,
  output logic [SW-1:0]             sec_o,
  output logic                      any_o
);
  logic [SW-1:0] sec_q;

  for (genvar g = 0; g < SECT_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_o[g] <= ERASED;
        mask_o[g]  <= 1'b0;
      end else if (clr_i) begin
        mask_o[g]  <= 1'b0;
      end else if (wr_i && ofs_i == OFS_W'(g)) begin
        bytes_o[g] <= data_i;
        mask_o[g]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sec_q <= '0;
    else if (wr_i && !(|mask_o)) sec_q <= sec_i;  // first byte fixes sector
  end

  assign sec_o = sec_q;
  assign any_o = |mask_o;
endmodule

// File: rtl/sfe_store.sv
module sfe_store
  import sfe_pkg::*;
#(
  parameter int NSECT = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  logic [$clog2(NSECT)-1:0]      sec_i,
  input  logic [SECT_BYTES-1:0][DW-1:0] bytes_i,
  input  logic [SECT_BYTES-1:0]         mask_i,
  input  logic [$clog2(NSECT)+OFS_W-1:0] rd_addr_i,
  output logic [DW-1:0]                 rd_data_o
);
  localparam int SW    = $clog2(NSECT);
  localparam int DEPTH = NSECT * SECT_BYTES;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit_i) begin
      // erase-then-program collapses to one write per byte
      for (int j = 0; j < SECT_BYTES; j++)
        mem[{sec_i, OFS_W'(j)}] <= mask_i[j] ? bytes_i[j] : ERASED;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  logic unused_sw;
  assign unused_sw = ^SW;
endmodule

// File: rtl/sector_flash_emu.sv
module sector_flash_emu
  import sfe_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int NSECT    = 32,
  parameter int BLC_CYC  = (CLK_HZ / 1_000_000) * 150,
  parameter int PROG_CYC = (CLK_HZ / 1_000) * 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o
);
  localparam int SW     = $clog2(NSECT);
  localparam int BLC_W  = $clog2(BLC_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  logic              wr_act, wr_start, wr_evt, rd_act, rd_start;
  logic [BUS_AW-1:0] wr_addr;
  logic [DW-1:0]     wr_data, store_rd, rd_val;
  cmd_e              cmd;
  cmd_step_e         cmd_step;
  ctl_state_e        state_q;
  logic [BLC_W-1:0]  tmr_q;
  logic [PROG_W-1:0] pcnt_q;
  logic [DW-1:0]     last_q;
  logic              tog_q, tog_nxt, id_q;
  logic [SECT_BYTES-1:0][DW-1:0] buf_bytes;
  logic [SECT_BYTES-1:0] buf_mask;
  logic [SW-1:0]     buf_sec;
  logic              buf_any, buf_clr, buf_wr, quiet_end, commit_w, busy_w;

  sfe_bus_if u_bus (
    .clk_i, .rst_ni, .addr_i, .data_i, .ce_ni, .oe_ni, .we_ni,
    .wr_act_o(wr_act), .wr_start_o(wr_start), .wr_evt_o(wr_evt),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_act_o(rd_act), .rd_start_o(rd_start)
  );

  sfe_cmd_fsm u_cmd (
    .clk_i, .rst_ni, .en_i(state_q == ST_IDLE), .wr_evt_i(wr_evt),
    .addr_i(wr_addr), .data_i(wr_data), .cmd_o(cmd), .step_o(cmd_step)
  );

  sfe_sector_buf #(.SW(SW)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .ofs_i(wr_addr[OFS_W-1:0]), .sec_i(wr_addr[OFS_W +: SW]), .data_i(wr_data),
    .bytes_o(buf_bytes), .mask_o(buf_mask), .sec_o(buf_sec), .any_o(buf_any)
  );

  sfe_store #(.NSECT(NSECT)) u_store (
    .clk_i, .rst_ni, .commit_i(commit_w), .sec_i(buf_sec),
    .bytes_i(buf_bytes), .mask_i(buf_mask),
    .rd_addr_i(addr_i[SW+OFS_W-1:0]), .rd_data_o(store_rd)
  );

  assign busy_w    = state_q == ST_BUSY;
  assign buf_clr   = state_q == ST_IDLE && cmd == CMD_PROG;
  assign buf_wr    = state_q == ST_LOAD && wr_evt;
  assign quiet_end = state_q == ST_LOAD && !wr_evt && !wr_act
                     && tmr_q == BLC_W'(BLC_CYC - 1);
  assign commit_w  = quiet_end && buf_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      pcnt_q  <= '0;
      last_q  <= '0;
      tog_q   <= 1'b0;
      id_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          unique case (cmd)
            CMD_PROG:   begin state_q <= ST_LOAD; tmr_q <= '0; end
            CMD_ID_ON:  id_q <= 1'b1;
            CMD_ID_OFF: id_q <= 1'b0;
            CMD_BAD: begin
              state_q <= ST_BUSY;
              pcnt_q  <= '0;
              last_q  <= wr_data;
              tog_q   <= 1'b0;
            end
            default: ;
          endcase
        end
        ST_LOAD: begin
          if (wr_evt) begin
            last_q <= wr_data;
            tmr_q  <= '0;
          end else if (wr_act) begin
            tmr_q  <= '0;
          end else if (quiet_end) begin
            state_q <= buf_any ? ST_BUSY : ST_IDLE;
            pcnt_q  <= '0;
            tog_q   <= 1'b0;
          end else begin
            tmr_q  <= tmr_q + 1'b1;
          end
        end
        ST_BUSY: begin
          tog_q <= tog_nxt;
          if (pcnt_q == PROG_W'(PROG_CYC - 1)) state_q <= ST_IDLE;
          else                                 pcnt_q  <= pcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tog_nxt = rd_start ? !tog_q : tog_q;

  always_comb begin
    if (busy_w)    rd_val = {~last_q[7], tog_nxt, last_q[5:0]};
    else if (id_q) rd_val = addr_i[0] ? ID_DEV : ID_MFR;
    else           rd_val = store_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_oe_o <= rd_act;
      data_o    <= rd_act ? rd_val : '0;
    end
  end

  logic unused_start;
  assign unused_start = wr_start;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       we_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       busy_i,
  input logic       commit_i,
  input logic       id_i,
  input logic [1:0] step_i
);
  a_r2_drive_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!ce_ni && !oe_ni && we_ni));

  a_r11_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> !data_oe_o);

  a_r7_no_commit_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !commit_i);

  a_r3_decoder_idle_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> step_i == 2'd0);

  a_r10_id_codes_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(id_i && !busy_i)) |-> (data_o == 8'h1F || data_o == 8'hBC));
endmodule

bind sector_flash_emu sfe_checker u_sfe_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
  .data_o(data_o), .data_oe_o(data_oe_o), .busy_i(busy_w), .commit_i(commit_w),
  .id_i(id_q), .step_i(cmd_step)
);

// File: tb/sector_flash_emu_tb_top.sv
module sector_flash_emu_tb_top;
  localparam int NSECT = 32;
  localparam int BLC   = 40;
  localparam int PROG  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0, dout;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dout_oe;
  int n_run = 0, n_fail = 0;
  logic [7:0] ref_mem [NSECT*64];
  logic [7:0] pend [64];
  logic       pmask [64];
  logic       tog;

  always #10 clk = ~clk;

  sector_flash_emu #(.NSECT(NSECT), .BLC_CYC(BLC), .PROG_CYC(PROG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .data_o(dout), .data_oe_o(dout_oe)
  );

  function automatic int idx(input logic [14:0] a);
    return int'(a[5:0]) + 64 * (int'(a[14:6]) % NSECT);
  endfunction

  function automatic logic [7:0] poll_val(input logic [7:0] d, input logic t);
    return {~d[7], t, d[5:0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic oe_lvl = 1'b1);
    @(negedge clk); addr = a; din = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); v = dout; oe = dout_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [14:0] a, input logic [7:0] exp);
    logic [7:0] v; logic o;
    rd(a, v, o);
    check({req, " oe"}, {7'd0, o}, 8'd1);
    check(req, v, exp);
  endtask

  task automatic unlock(input logic [7:0] op);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, op);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pend_clear();
    for (int i = 0; i < 64; i++) pmask[i] = 1'b0;
  endtask

  task automatic load(input logic [8:0] sec, input logic [5:0] ofs, input logic [7:0] d);
    wr({sec, ofs}, d); pend[ofs] = d; pmask[ofs] = 1'b1;
  endtask

  task automatic model_commit(input logic [8:0] sec);
    for (int i = 0; i < 64; i++)
      ref_mem[idx({sec, 6'(i)})] = pmask[i] ? pend[i] : 8'hFF;
  endtask

  task automatic sector_chk(input string req, input logic [8:0] sec);
    for (int i = 0; i < 64; i++) rd_chk(req, {sec, 6'(i)}, ref_mem[idx({sec, 6'(i)})]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v; logic o;
    logic [8:0] s;
    void'($urandom(32'd1234));
    for (int i = 0; i < NSECT*64; i++) ref_mem[i] = 8'hFF;
    idle(3);
    check("R1 oe at reset", {7'd0, dout_oe}, 8'd0);
    rst_n = 1'b1;
    idle(2);
    rd_chk("R1", 15'h0000, 8'hFF);
    rd_chk("R1", 15'h7FFF, 8'hFF);

    // R2: no drive with oe or ce high
    @(negedge clk); addr = 15'h10; ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); check("R2 ce high", {7'd0, dout_oe}, 8'd0);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); check("R2 oe high", {7'd0, dout_oe}, 8'd0);
    ce_n = 1'b1; idle(1);

    // R4 R6: random sectors, random order, folded sector index
    for (int k = 0; k < 5; k++) begin
      s = 9'($urandom % 512);
      pend_clear();
      unlock(8'hA0);
      for (int b = 0; b < 1 + ($urandom % 20); b++)
        load(s, 6'($urandom % 64), 8'($urandom));
      idle(BLC + PROG + 10);
      model_commit(s);
      sector_chk("R6", s);
      rd_chk("R6 other sector", {s + 9'd1, 6'd7}, ref_mem[idx({s + 9'd1, 6'd7})]);
    end

    // R5 R8 R9 R7: window extended, polling and toggle, busy end
    s = 9'd3; pend_clear();
    unlock(8'hA0);
    load(s, 6'd1, 8'h81);
    idle(BLC - 10);
    load(s, 6'd2, 8'h3C);
    idle(BLC + 5);
    tog = 1'b0;
    for (int r = 0; r < 4; r++) begin
      tog = ~tog;
      rd_chk("R8 R9 poll", {s, 6'd2}, poll_val(8'h3C, tog));
    end
    idle(PROG - 40);
    tog = ~tog;
    rd_chk("R7 still busy", {s, 6'd1}, poll_val(8'h3C, tog));
    idle(30);
    model_commit(s);
    rd_chk("R5 extended window", {s, 6'd1}, 8'h81);
    rd_chk("R5 extended window", {s, 6'd2}, 8'h3C);
    rd_chk("R6 erased", {s, 6'd0}, 8'hFF);

    // R5: timeout then late byte ignored
    s = 9'd5; pend_clear();
    unlock(8'hA0);
    load(s, 6'd3, 8'h44);
    idle(BLC + 20);
    wr({s, 6'd4}, 8'h99);
    idle(PROG + 10);
    model_commit(s);
    rd_chk("R5 closed", {s, 6'd3}, 8'h44);
    rd_chk("R5 late byte", {s, 6'd4}, 8'hFF);

    // R7: protection restored after busy
    wr({s, 6'd3}, 8'h5A);
    rd_chk("R7 poll after plain write", {s, 6'd3}, poll_val(8'h5A, 1'b1));
    idle(PROG + 10);
    rd_chk("R7 protected", {s, 6'd3}, 8'h44);

    // R3: wrong third step and wrong first step
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr({s, 6'd3}, 8'hA0);
    rd_chk("R3 bad step busy", {s, 6'd3}, poll_val(8'hA0, 1'b1));
    idle(PROG + 10);
    rd_chk("R3 nothing stored", {s, 6'd3}, 8'h44);
    wr(15'h5555, 8'hAB);
    rd_chk("R3 bad key busy", 15'h5555, poll_val(8'hAB, 1'b1));
    idle(PROG + 10);

    // R11: strobe with oe low ignored; empty window ends without busy
    unlock(8'hA0);
    wr({s, 6'd3}, 8'h12, 1'b0);
    idle(BLC + 10);
    rd_chk("R11 inhibited", {s, 6'd3}, 8'h44);
    rd_chk("R5 empty window no busy", {s, 6'd3}, 8'h44);

    // R10: identification mode
    unlock(8'h90);
    rd_chk("R10 mfr", 15'h0000, 8'h1F);
    rd_chk("R10 dev", 15'h0001, 8'hBC);
    rd_chk("R10 dev odd", {s, 6'd3}, 8'hBC);
    unlock(8'hF0);
    rd_chk("R10 exit", {s, 6'd3}, 8'h44);
    rd(15'h0000, v, o);
    check("R10 array intact", v, ref_mem[0]);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule